// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block holds the configuration and pointer state of four circular descriptor rings for a network DMA engine: a receive free-buffer ring, a receive completed ring, a transmit request ring and a transmit completion ring. Each ring has a base address, a depth, a write pointer and a read pointer. All of them sit behind a simple 32-bit register bus with writes on a strobe and reads that are combinational. On every ring, software moves one pointer through the bus. The DMA engine moves the other pointer through a per-ring advance strobe.

Pointers are held as descriptor indices but appear on the bus as byte offsets of 32-byte descriptors. The block gives the DMA engine an empty flag, a full flag and the index of the hardware-owned pointer for each ring. One slot of every ring always stays unused, so a full ring and an empty ring look different. The base address and the depth are protected by per-ring unlock bits. A global gate register allows or blocks each hardware advance.

Top module: `dring_ptr_mgr`

## Requirements
- R1: After reset, every ring has base 0, depth 64 descriptors, both indices 0, both unlock bits clear, `ring_empty` = 4'b1111 and `ring_full` = 0. The gate register is 0.
- R2: Ring r (0 = receive free, 1 = receive completed, 2 = transmit request, 3 = transmit completion) occupies addresses r*0x20 + {0x00 base, 0x04 depth, 0x08 write pointer, 0x0C read pointer, 0x10 unlock}. The gate register is at 0x80. Any other address reads 0 and ignores writes. A write takes effect at the next clock edge, and a read returns the current value in the same cycle.
- R3: A base write takes effect only while unlock bit 2 of that ring is set. The unlock register keeps bit 2 (base) and bit 1 (depth) and reads back with bit 0 at 0.
- R4: A depth write takes effect only while unlock bit 1 is set. The depth is written as the descriptor count shifted left by 3 and reads back the same way. A count above 64 is stored as 64.
- R5: An accepted depth write sets both indices of that ring to 0, and this overrides a hardware advance in the same cycle.
- R6: Pointers read back as index*32. A software write to a software-owned pointer stores wdata>>5, or 0 if that index is not below the depth. Software owns the write pointer of rings 0 and 2 and the read pointer of rings 1 and 3.
- R7: Software writes to the hardware-owned pointer (read pointer of rings 0 and 2, write pointer of rings 1 and 3) are ignored.
- R8: An accepted hardware advance moves the hardware-owned index by one. The index wraps to 0 when it would reach the depth. `hw_idx` slice r shows that index.
- R9: A ring is empty when its two indices are equal. It is full when the write index advanced once (with wrap) equals the read index.
- R10: A hardware advance is ignored on an empty ring when hardware owns the read pointer, and on a full ring when hardware owns the write pointer.
- R11: Gate bit 3 enables ring 1, bit 2 enables ring 0, bit 1 enables ring 3 and bit 0 enables ring 2. An advance is ignored while the ring's gate bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| hw_adv | input | 4 | Per-ring advance strobe of the hardware-owned pointer |
| ring_empty | output | 4 | Per-ring empty flag |
| ring_full | output | 4 | Per-ring full flag |
| hw_idx | output | 28 | Four 7-bit hardware-owned indices, ring r at bits [7r+6:7r] |

## Verification
On every cycle, the assertions check the following: a locked base or depth write changes nothing, an accepted depth write zeroes both indices, a gated or blocked advance leaves the hardware index alone, and indices stay below the depth. Only the bench scenarios can show the rest. These are the exact arithmetic of wrap at odd depths, the clamping of oversized depths and pointers, the mapping of gate bits to rings, and the address decode with readback encodings. The bench shows them by comparing every output against a reference model while bus writes and advances are mixed at random.

// File: rtl/dring_pkg.sv
package dring_pkg;
    parameter int unsigned DR_DEPTH_MAX = 64;
    localparam int unsigned DR_CNT_W = $clog2(DR_DEPTH_MAX + 1);
    localparam int unsigned DR_NRING = 4;
    localparam int unsigned DR_NFIELD = 5;
    localparam int unsigned DR_DESC_SHIFT = 5;
    localparam int unsigned DR_DEPTH_SHIFT = 3;

    typedef enum logic [2:0] {
        F_BASE  = 3'd0,
        F_DEPTH = 3'd1,
        F_WPTR  = 3'd2,
        F_RPTR  = 3'd3,
        F_CTRL  = 3'd4
    } dr_field_e;

    typedef struct packed {
        logic [31:0]         base;
        logic [DR_CNT_W-1:0] depth;
        logic [DR_CNT_W-1:0] widx;
        logic [DR_CNT_W-1:0] ridx;
        logic                en_base;
        logic                en_depth;
    } dr_ring_t;

    // Gate register bit that enables each ring's hardware advance
    function automatic int dr_gate_bit(input int r);
        case (r)
            0: return 2;
            1: return 3;
            2: return 0;
            default: return 1;
        endcase
    endfunction
endpackage

// File: rtl/dring_decode.sv
module dring_decode
    import dring_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                                 wr,
    input  logic [ADDR_W-1:0]                    addr,
    output logic [DR_NRING-1:0][DR_NFIELD-1:0]   wsel,
    output logic                                 gate_we,
    output logic                                 hit_ring,
    output logic                                 hit_gate,
    output logic [$clog2(DR_NRING)-1:0]          ring_no,
    output logic [2:0]                           fld
);
    localparam int unsigned RN_W = $clog2(DR_NRING);
    localparam int unsigned RING_LSB = 5;
    localparam int unsigned TOP_LSB = RING_LSB + RN_W;
    localparam logic [ADDR_W-1:0] GATE_ADDR = ADDR_W'(8'h80);

    always_comb begin
        ring_no  = addr[RING_LSB +: RN_W];
        fld      = addr[4:2];
        hit_gate = (addr == GATE_ADDR);
        hit_ring = (addr[ADDR_W-1:TOP_LSB] == '0) && (addr[1:0] == 2'b00)
                   && (fld < 3'(DR_NFIELD));
        gate_we  = wr && hit_gate;
        for (int r = 0; r < DR_NRING; r++) begin
            for (int f = 0; f < DR_NFIELD; f++) begin
                wsel[r][f] = wr && hit_ring && (ring_no == r[RN_W-1:0])
                             && (fld == f[2:0]);
            end
        end
    end
endmodule

// File: rtl/dring_ring.sv
module dring_ring
    import dring_pkg::*;
#(
    parameter bit HW_WRITES = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DR_NFIELD-1:0] wr_sel,
    input  logic [31:0]          wr_data,
    input  logic                 hw_adv,
    input  logic                 gate,
    output dr_ring_t             st,
    output logic                 empty,
    output logic                 full,
    output logic [DR_CNT_W-1:0]  hw_idx
);
    localparam int unsigned PW = 32 - DR_DESC_SHIFT;
    localparam int unsigned DW = 32 - DR_DEPTH_SHIFT;
    localparam int unsigned NW = DR_CNT_W + 1;

    dr_ring_t q_d, q_q;
    logic     adv_ok;

    function automatic logic [DR_CNT_W-1:0] step_idx(input logic [DR_CNT_W-1:0] i,
                                                      input logic [DR_CNT_W-1:0] d);
        logic [NW-1:0] n;
        n = NW'(i) + NW'(1);
        return (n >= NW'(d)) ? '0 : n[DR_CNT_W-1:0];
    endfunction

    function automatic logic [DR_CNT_W-1:0] fit_ptr(input logic [31:0] w,
                                                     input logic [DR_CNT_W-1:0] d);
        logic [PW-1:0] v;
        v = w[31:DR_DESC_SHIFT];
        return (v < PW'(d)) ? v[DR_CNT_W-1:0] : '0;
    endfunction

    function automatic logic [DR_CNT_W-1:0] clamp_depth(input logic [31:0] w);
        logic [DW-1:0] v;
        v = w[31:DR_DEPTH_SHIFT];
        return (v > DW'(DR_DEPTH_MAX)) ? DR_CNT_W'(DR_DEPTH_MAX) : v[DR_CNT_W-1:0];
    endfunction

    assign empty = (q_q.widx == q_q.ridx);
    assign full  = (step_idx(q_q.widx, q_q.depth) == q_q.ridx);
    assign st    = q_q;

    generate
        if (HW_WRITES) begin : g_produce
            assign adv_ok = hw_adv && gate && !full;
            assign hw_idx = q_q.widx;
            p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_adv && full && !(wr_sel[F_DEPTH] && q_q.en_depth)) |=> $stable(hw_idx));
        end else begin : g_consume
            assign adv_ok = hw_adv && gate && !empty;
            assign hw_idx = q_q.ridx;
            p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_adv && empty && !(wr_sel[F_DEPTH] && q_q.en_depth)) |=> $stable(hw_idx));
        end
    endgenerate

    always_comb begin
        q_d = q_q;
        if (adv_ok) begin
            if (HW_WRITES) q_d.widx = step_idx(q_q.widx, q_q.depth);
            else           q_d.ridx = step_idx(q_q.ridx, q_q.depth);
        end
        if (wr_sel[F_CTRL]) begin
            q_d.en_base  = wr_data[2];
            q_d.en_depth = wr_data[1];
        end
        if (wr_sel[F_BASE] && q_q.en_base) q_d.base = wr_data;
        if (wr_sel[F_WPTR] && !HW_WRITES) q_d.widx = fit_ptr(wr_data, q_q.depth);
        if (wr_sel[F_RPTR] && HW_WRITES)  q_d.ridx = fit_ptr(wr_data, q_q.depth);
        if (wr_sel[F_DEPTH] && q_q.en_depth) begin
            q_d.depth = clamp_depth(wr_data);
            q_d.widx  = '0;
            q_d.ridx  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q          <= '0;
            q_q.depth    <= DR_CNT_W'(DR_DEPTH_MAX);
        end else begin
            q_q <= q_d;
        end
    end

    p_base_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[F_BASE] && !q_q.en_base) |=> $stable(q_q.base));
    p_depth_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[F_DEPTH] && !q_q.en_depth) |=> $stable(q_q.depth));
    p_depth_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[F_DEPTH] && q_q.en_depth) |=> (q_q.widx == '0 && q_q.ridx == '0));
    p_gated_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate && !wr_sel[F_DEPTH]) |=> $stable(hw_idx));
    p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q.depth != '0) |-> (q_q.widx < q_q.depth && q_q.ridx < q_q.depth));
endmodule

// File: rtl/dring_ptr_mgr.sv
module dring_ptr_mgr
    import dring_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    input  logic [DR_NRING-1:0]          hw_adv,
    output logic [DR_NRING-1:0]          ring_empty,
    output logic [DR_NRING-1:0]          ring_full,
    output logic [DR_NRING*DR_CNT_W-1:0] hw_idx
);
    localparam int unsigned RN_W = $clog2(DR_NRING);

    logic [DR_NRING-1:0][DR_NFIELD-1:0] wsel;
    logic                gate_we, hit_ring, hit_gate;
    logic [RN_W-1:0]     ring_no;
    logic [2:0]          fld;
    logic [DR_NRING-1:0] gate_d, gate_q;
    dr_ring_t            ring_st [DR_NRING];
    logic [DR_CNT_W-1:0] ring_hw [DR_NRING];

    dring_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wsel     (wsel),
        .gate_we  (gate_we),
        .hit_ring (hit_ring),
        .hit_gate (hit_gate),
        .ring_no  (ring_no),
        .fld      (fld)
    );

    always_comb begin
        gate_d = gate_q;
        if (gate_we) gate_d = bus_wdata[DR_NRING-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    generate
        for (genvar r = 0; r < DR_NRING; r++) begin : g_ring
            localparam int GB = dr_gate_bit(r);
            dring_ring #(.HW_WRITES((r % 2) == 1)) u_ring (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_sel  (wsel[r]),
                .wr_data (bus_wdata),
                .hw_adv  (hw_adv[r]),
                .gate    (gate_q[GB]),
                .st      (ring_st[r]),
                .empty   (ring_empty[r]),
                .full    (ring_full[r]),
                .hw_idx  (ring_hw[r])
            );
            assign hw_idx[r*DR_CNT_W +: DR_CNT_W] = ring_hw[r];
        end
    endgenerate

    always_comb begin
        dr_ring_t sel;
        sel = ring_st[ring_no];
        bus_rdata = '0;
        if (hit_gate) begin
            bus_rdata = 32'(gate_q);
        end else if (hit_ring) begin
            case (fld)
                F_BASE:  bus_rdata = sel.base;
                F_DEPTH: bus_rdata = 32'(sel.depth) << DR_DEPTH_SHIFT;
                F_WPTR:  bus_rdata = 32'(sel.widx) << DR_DESC_SHIFT;
                F_RPTR:  bus_rdata = 32'(sel.ridx) << DR_DESC_SHIFT;
                F_CTRL:  bus_rdata = {29'd0, sel.en_base, sel.en_depth, 1'b0};
                default: bus_rdata = '0;
            endcase
        end
    end

    p_gate_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_we |=> $stable(gate_q));
endmodule

// File: tb/dring_ptr_mgr_tb_top.sv
module dring_ptr_mgr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  hw_adv = '0;
    logic [3:0]  ring_empty, ring_full;
    logic [27:0] hw_idx;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_base [4];
    int unsigned m_depth [4];
    int unsigned m_w [4];
    int unsigned m_r [4];
    logic [1:0]  m_en [4];
    logic [3:0]  m_gate;

    always #2 clk = ~clk;

    dring_ptr_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_adv(hw_adv),
        .ring_empty(ring_empty), .ring_full(ring_full), .hw_idx(hw_idx)
    );

    function automatic int gbit(input int r);
        return (r == 0) ? 2 : (r == 1) ? 3 : (r == 2) ? 0 : 1;
    endfunction

    function automatic int unsigned nxt(input int unsigned i, input int unsigned d);
        return (i + 1 >= d) ? 0 : i + 1;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int r;
        if (a == 8'h80) return {28'd0, m_gate};
        if (a[7] != 1'b0 || a[1:0] != 2'b00 || a[4:2] > 3'd4) return 32'd0;
        r = int'(a[6:5]);
        case (a[4:2])
            3'd0: return m_base[r];
            3'd1: return m_depth[r] * 8;
            3'd2: return m_w[r] * 32;
            3'd3: return m_r[r] * 32;
            default: return {29'd0, m_en[r], 1'b0};
        endcase
    endfunction

    function automatic void m_apply(input logic w, input logic [7:0] a,
                                    input logic [31:0] d, input logic [3:0] adv);
        for (int r = 0; r < 4; r++) begin
            bit emp, ful;
            emp = (m_w[r] == m_r[r]);
            ful = (nxt(m_w[r], m_depth[r]) == m_r[r]);
            if (adv[r] && m_gate[gbit(r)]) begin
                if (r % 2 == 1) begin
                    if (!ful) m_w[r] = nxt(m_w[r], m_depth[r]);
                end else begin
                    if (!emp) m_r[r] = nxt(m_r[r], m_depth[r]);
                end
            end
        end
        if (!w) return;
        if (a == 8'h80) begin
            m_gate = d[3:0];
        end else if (a[7] == 1'b0 && a[1:0] == 2'b00 && a[4:2] <= 3'd4) begin
            int r;
            int unsigned v;
            r = int'(a[6:5]);
            case (a[4:2])
                3'd0: if (m_en[r][1]) m_base[r] = d;
                3'd1: if (m_en[r][0]) begin
                    v = d >> 3;
                    m_depth[r] = (v > 64) ? 64 : v;
                    m_w[r] = 0;
                    m_r[r] = 0;
                end
                3'd2: if (r % 2 == 0) begin
                    v = d >> 5;
                    m_w[r] = (v < m_depth[r]) ? v : 0;
                end
                3'd3: if (r % 2 == 1) begin
                    v = d >> 5;
                    m_r[r] = (v < m_depth[r]) ? v : 0;
                end
                default: m_en[r] = d[2:1];
            endcase
        end
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_outs();
        for (int r = 0; r < 4; r++) begin
            chk(32'(ring_empty[r]), 32'(m_w[r] == m_r[r]), "R9 empty flag");
            chk(32'(ring_full[r]), 32'(nxt(m_w[r], m_depth[r]) == m_r[r]), "R9 full flag");
            chk(32'(hw_idx[r*7 +: 7]), (r % 2 == 1) ? m_w[r] : m_r[r], "R8 hw index");
        end
    endtask

    task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic [3:0] adv);
        bus_wr = w; bus_addr = a; bus_wdata = d; hw_adv = adv;
        @(posedge clk);
        m_apply(w, a, d, adv);
        @(negedge clk);
        bus_wr = 1'b0; hw_adv = '0;
        check_outs();
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata, m_read(a), tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 4'h0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int r = 0; r < 4; r++) begin
            m_base[r] = '0; m_depth[r] = 64; m_w[r] = 0; m_r[r] = 0; m_en[r] = '0;
        end
        m_gate = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(32'(ring_empty), 32'hF, "R1 empty after reset");
        chk(32'(ring_full), 32'h0, "R1 full after reset");
        chk(32'(hw_idx), 32'h0, "R1 hw_idx after reset");
        rd(8'h04, "R1 depth reset");
        rd(8'h80, "R1 gate reset");
        rd(8'h70, "R1 ctrl reset");

        // R3 base locked, then unlocked
        wr(8'h20, 32'hDEAD_BEE0);
        rd(8'h20, "R3 locked base write");
        wr(8'h30, 32'h4);
        rd(8'h30, "R3 unlock readback");
        wr(8'h20, 32'hDEAD_BEE0);
        rd(8'h20, "R3 unlocked base write");

        // R4 depth unlock, clamp
        wr(8'h04, 32'd8 << 3);
        rd(8'h04, "R4 locked depth write");
        wr(8'h10, 32'h2);
        wr(8'h04, 32'd1000 << 3);
        rd(8'h04, "R4 depth clamp");
        wr(8'h04, 32'd8 << 3);
        rd(8'h04, "R4 depth 8");

        // R6 / R7 pointer writes on ring 0
        wr(8'h08, 32'd3 << 5);
        rd(8'h08, "R6 sw write pointer");
        wr(8'h08, 32'd9 << 5);
        rd(8'h08, "R6 out of range pointer");
        wr(8'h08, 32'd5 << 5);
        wr(8'h0C, 32'd2 << 5);
        rd(8'h0C, "R7 hw-owned pointer ignored");

        // R11 gate on ring 0
        cyc(1'b0, 8'h00, 32'h0, 4'h1);
        chk(32'(hw_idx[6:0]), 32'd0, "R11 gated advance ignored");
        wr(8'h80, 32'h4);
        cyc(1'b0, 8'h00, 32'h0, 4'h1);
        chk(32'(hw_idx[6:0]), 32'd1, "R8 consume advances");

        // R10 consume on empty ring 0
        wr(8'h08, 32'd1 << 5);
        cyc(1'b0, 8'h00, 32'h0, 4'h1);
        chk(32'(hw_idx[6:0]), 32'd1, "R10 consume on empty ignored");

        // R9 / R10 / R8 produce on ring 1, depth 4
        wr(8'h30, 32'h2);
        wr(8'h24, 32'd4 << 3);
        wr(8'h80, 32'h8);
        repeat (3) cyc(1'b0, 8'h00, 32'h0, 4'h2);
        chk(32'(ring_full[1]), 32'd1, "R9 ring full");
        cyc(1'b0, 8'h00, 32'h0, 4'h2);
        chk(32'(hw_idx[13:7]), 32'd3, "R10 produce on full ignored");
        wr(8'h2C, 32'd3 << 5);
        cyc(1'b0, 8'h00, 32'h0, 4'h2);
        chk(32'(hw_idx[13:7]), 32'd0, "R8 wrap at depth");

        // R5 depth write clears pointers, beats same-cycle advance
        cyc(1'b1, 8'h24, 32'd6 << 3, 4'h2);
        chk(32'(hw_idx[13:7]), 32'd0, "R5 depth write clears");
        rd(8'h2C, "R5 read pointer cleared");

        // R2 unmapped address
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, "R2 unmapped read");
        rd(8'h84, "R2 unmapped near gate");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            int k;
            logic [7:0]  a;
            logic [31:0] d;
            r = int'($urandom % 4);
            k = int'($urandom % 8);
            d = $urandom;
            case (k)
                0: begin a = 8'(r * 32 + 4); d = (1 + $urandom % 70) << 3; end
                1: begin a = 8'(r * 32 + 8); d = ($urandom % 80) << 5; end
                2: begin a = 8'(r * 32 + 12); d = ($urandom % 80) << 5; end
                3: begin a = 8'(r * 32 + 16); d = $urandom % 8; end
                4: a = 8'h80;
                5: a = 8'(r * 32);
                default: a = 8'($urandom);
            endcase
            cyc(($urandom % 3) != 0, a, d, 4'($urandom));
            if (i % 7 == 0) rd(8'($urandom), "R2 random readback");
        end
        summary();
    end
endmodule